// File: doc/BRIEF.md
# SPI Controller with Chip-Select Decode

The block is a serial peripheral interface controller configured by a single mode word. As master it shifts one byte at a time, MSB first, on its own serial clock. It drives four peripheral-select lines, either wired directly to peripherals or carrying a code for an external 4-to-16 decoder. As slave it takes in a byte on its serial input while its select pin is held low. Software writes and reads through a simple register bus: mode, lock, transmit, receive, status and four clock-timing slots.

For each transfer, the select code comes from the mode word or from bits 19:16 of the transmit word. That code picks one of four timing slots. Each slot sets the serial clock half-period. When the select code changes, the lines rest at all ones for a programmed gap. When the code stays the same, the lines remain asserted from one byte to the next. Three options are set in the mode word. The receive-wait option holds back a master transfer until the previous byte has been read. Loopback feeds the serial output back as the serial input. The fault option watches the fault pin and stops the master when that pin goes low.

Top module: `spiCsCtrl`

## Requirements
- R1: After reset, the select lines read 4'hF, the serial clock is low, the mode word reads 0 (slave), and status reads 0x2. Status bits: 0 = receive full, 1 = transmit slot free, 2 = overrun, 3 = mode fault, 4 = busy.
- R2: A master transfer sends the transmit byte MSB first on the serial output while the clock is low. It samples the serial input on each rising clock edge. The clock idles low, and each half-period lasts (slot value + 1) system clocks. After 8 bits the received byte sits at address 3 and the receive-full bit is set.
- R3: With the loopback bit (mode bit 7) set, the byte received equals the byte sent, whatever the serial input pin does.
- R4: With mode bit 1 clear, the select code is mode bits 19:16. With mode bit 1 set, it is bits 19:16 of the transmit word. The code appears on the select lines during the transfer and stays there afterwards.
- R5: With mode bit 2 set (decoded lines), the timing slot is code bits 3:2. With mode bit 2 clear (direct lines), the slot is the position of the lowest zero bit of the code, and code 4'hF uses slot 3. Slots live at addresses 8 to 11.
- R6: When the code changes from one asserted value to another, the lines first stay at 4'hF for at least the mode bits 31:24 count of clocks. When the code does not change, the lines never return to 4'hF between bytes.
- R7: With mode bit 5 set, a master transfer does not start while the receive register holds an unread byte. It starts once that byte is read.
- R8: A byte that completes while receive-full is set and not being read sets the overrun bit and replaces the stored byte. Writing 1 to status bit 2 clears overrun.
- R9: A receive read in the same cycle as a transfer completion returns the older byte. Receive-full stays set, and no overrun is flagged.
- R10: In master mode with mode bit 4 clear, a low fault pin sets status bit 3. It aborts the transfer, holds the lines at 4'hF and the clock low, and blocks further transfers until 1 is written to status bit 3. With mode bit 4 set, the pin has no effect.
- R11: While lock bit 0 at address 1 is set, writes to the mode word are ignored.
- R12: In slave mode the select lines stay at 4'hF. While the fault pin is low, the byte presented on the serial data input is sampled on rising edges of the input clock and lands in the receive register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (reading address 3 consumes the byte) |
| addr | input | 4 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational |
| sckOut | output | 1 | Master serial clock |
| sckIn | input | 1 | Slave serial clock |
| mosiOut | output | 1 | Master serial data out |
| mosiIn | input | 1 | Slave serial data in |
| misoIn | input | 1 | Master serial data in |
| misoOut | output | 1 | Slave serial data out |
| pcsN | output | 4 | Peripheral-select lines, active low or encoded |
| faultN | input | 1 | Fault pin in master mode, select in slave mode |

## Verification
Two events can land in the same clock edge: software consuming the receive register, and the engine depositing a new byte. The bench provokes this with the fastest timing slot. It counts rising serial clock edges and raises the receive read so that it lands exactly on the final falling edge. The result is judged at the ports: the read must return the older byte, status must then show receive-full without overrun, and a second read must return the new byte. The same priority question arises between a new overrun and its clear, and the bench also exercises that clear.

// File: rtl/spiPkg.sv
package spiPkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 4;
  localparam int BYTE_W   = 8;
  localparam int DIV_W    = 8;
  localparam int CS_W     = 4;
  localparam int NUM_TIM  = 4;
  localparam int GAP_W    = 8;
  localparam int TIDX_W   = $clog2(NUM_TIM);
  localparam int BITCNT_W = $clog2(BYTE_W);

  localparam logic [ADDR_W-1:0] A_MODE = 4'd0;
  localparam logic [ADDR_W-1:0] A_LOCK = 4'd1;
  localparam logic [ADDR_W-1:0] A_TX   = 4'd2;
  localparam logic [ADDR_W-1:0] A_RX   = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd4;
  localparam logic [ADDR_W-1:0] A_TIM0 = 4'd8;

  localparam int S_RXFULL = 0;
  localparam int S_TXRDY  = 1;
  localparam int S_OVR    = 2;
  localparam int S_FAULT  = 3;
  localparam int S_BUSY   = 4;

  localparam int TXPCS_LSB = 16;

  localparam logic [CS_W-1:0]  CS_NONE   = '1;
  localparam logic [REG_W-1:0] MODE_MASK = 32'hFF0F_00B7;

  typedef struct packed {
    logic [7:0] dlyCs;
    logic [3:0] padHi;
    logic [3:0] pcs;
    logic [7:0] padMid;
    logic       loopBack;
    logic       rsv6;
    logic       waitRead;
    logic       faultOff;
    logic       rsv3;
    logic       decode;
    logic       varSel;
    logic       master;
  } modeReg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_SHIFT} ctlState_t;

  typedef struct packed {
    logic              start;
    logic              abort;
    logic              rxRead;
    logic              ovrClear;
    logic              master;
    logic              loopBack;
    logic              slaveSel;
    logic [BYTE_W-1:0] txByte;
    logic [DIV_W-1:0]  div;
  } dpCmd_t;

  typedef struct packed {
    logic              busy;
    logic              rxFull;
    logic              overrun;
    logic [BYTE_W-1:0] rxData;
  } dpStat_t;
endpackage

// File: rtl/spiCtrl.sv
module spiCtrl
  import spiPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic              faultN,
  output logic [CS_W-1:0]   pcsN,
  output dpCmd_t            cmd,
  input  dpStat_t           stat,
  output modeReg_t          modeWord,
  output logic              lockBit,
  output logic              modeFault
);
  modeReg_t          mode;
  logic              lock;
  logic [DIV_W-1:0]  timing [NUM_TIM];
  logic              txValid;
  logic [BYTE_W-1:0] txByte;
  logic [CS_W-1:0]   txPcs;
  logic              fault;
  logic [1:0]        faultSync;
  ctlState_t         state;
  logic [GAP_W-1:0]  gapCnt;
  logic [CS_W-1:0]   lines;

  logic [CS_W-1:0]   target;
  logic [TIDX_W-1:0] tIdx;
  logic              canStart;
  logic              pinLow;
  logic              busyAll;

  function automatic logic [TIDX_W-1:0] pickSlot(input logic dec, input logic [CS_W-1:0] code);
    logic [TIDX_W-1:0] slot;
    slot = TIDX_W'(NUM_TIM - 1);
    if (dec) begin
      slot = code[CS_W-1 -: TIDX_W];
    end else begin
      for (int i = NUM_TIM - 2; i >= 0; i--) begin
        if (!code[i]) slot = TIDX_W'(i);
      end
    end
    return slot;
  endfunction

  assign pinLow   = !faultSync[1];
  assign target   = mode.varSel ? txPcs : mode.pcs;
  assign tIdx     = pickSlot(mode.decode, target);
  assign canStart = txValid && mode.master && !fault && !(mode.waitRead && stat.rxFull);
  assign busyAll  = txValid || (state != ST_IDLE) || stat.busy;

  always_comb begin
    cmd          = '0;
    cmd.start    = (state == ST_IDLE) && canStart && (lines == target);
    cmd.abort    = fault || !mode.master;
    cmd.rxRead   = rdEn && (addr == A_RX);
    cmd.ovrClear = wrEn && (addr == A_STAT) && wrData[S_OVR];
    cmd.master   = mode.master;
    cmd.loopBack = mode.loopBack;
    cmd.slaveSel = pinLow;
    cmd.txByte   = txByte;
    cmd.div      = timing[tIdx];
  end

  // register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= '0;
      lock    <= 1'b0;
      txByte  <= '0;
      txPcs   <= '0;
      for (int i = 0; i < NUM_TIM; i++) timing[i] <= '0;
    end else if (wrEn) begin
      if (addr == A_MODE && !lock) mode <= modeReg_t'(wrData & MODE_MASK);
      if (addr == A_LOCK) lock <= wrData[0];
      if (addr == A_TX && !txValid) begin
        txByte <= wrData[BYTE_W-1:0];
        txPcs  <= wrData[TXPCS_LSB +: CS_W];
      end
      for (int i = 0; i < NUM_TIM; i++) begin
        if (addr == A_TIM0 + ADDR_W'(i)) timing[i] <= wrData[DIV_W-1:0];
      end
    end
  end

  // fault detection: a new fault wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultSync <= 2'b11;
      fault     <= 1'b0;
    end else begin
      faultSync <= {faultSync[0], faultN};
      if (mode.master && !mode.faultOff && pinLow) fault <= 1'b1;
      else if (wrEn && addr == A_STAT && wrData[S_FAULT]) fault <= 1'b0;
    end
  end

  // select sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      gapCnt  <= '0;
      lines   <= CS_NONE;
      txValid <= 1'b0;
    end else begin
      if (wrEn && addr == A_TX && !txValid) txValid <= 1'b1;
      if (fault || !mode.master) begin
        state <= ST_IDLE;
        lines <= CS_NONE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (canStart) begin
              if (lines == target) begin
                txValid <= 1'b0;
                state   <= ST_SHIFT;
              end else if (lines == CS_NONE) begin
                lines <= target;
              end else begin
                lines  <= CS_NONE;
                gapCnt <= mode.dlyCs;
                state  <= ST_GAP;
              end
            end
          end
          ST_GAP: begin
            if (gapCnt == '0) state <= ST_IDLE;
            else gapCnt <= gapCnt - 1'b1;
          end
          ST_SHIFT: begin
            if (!stat.busy) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (addr)
        A_MODE: rdData = mode;
        A_LOCK: rdData = REG_W'(lock);
        A_RX:   rdData = REG_W'(stat.rxData);
        A_STAT: begin
          rdData[S_RXFULL] = stat.rxFull;
          rdData[S_TXRDY]  = !txValid;
          rdData[S_OVR]    = stat.overrun;
          rdData[S_FAULT]  = fault;
          rdData[S_BUSY]   = busyAll;
        end
        default: begin
          for (int i = 0; i < NUM_TIM; i++) begin
            if (addr == A_TIM0 + ADDR_W'(i)) rdData = REG_W'(timing[i]);
          end
        end
      endcase
    end
  end

  assign pcsN      = lines;
  assign modeWord  = mode;
  assign lockBit   = lock;
  assign modeFault = fault;
endmodule

// File: rtl/spiDatapath.sv
module spiDatapath
  import spiPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpCmd_t  cmd,
  output dpStat_t stat,
  output logic    sckOut,
  output logic    mosiOut,
  input  logic    misoIn,
  output logic    misoOut,
  input  logic    sckIn,
  input  logic    mosiIn
);
  // master engine
  logic                busy;
  logic                sck;
  logic [BYTE_W-1:0]   txShift;
  logic [BYTE_W-1:0]   rxShift;
  logic [BITCNT_W-1:0] bitCnt;
  logic [DIV_W-1:0]    cnt;
  logic [DIV_W-1:0]    divHold;
  logic                rxIn;
  logic                mDone;

  // slave engine
  logic [2:0]          sckSync;
  logic [1:0]          mosiSync;
  logic [BYTE_W-1:0]   slvShift;
  logic [BYTE_W-1:0]   slvTx;
  logic [BITCNT_W-1:0] slvBits;
  logic                slvActive;
  logic                sRise;
  logic                sFall;
  logic                sDone;

  // receive holding
  logic                deliver;
  logic [BYTE_W-1:0]   newByte;
  logic [BYTE_W-1:0]   rxData;
  logic                rxFull;
  logic                overrun;

  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);

  assign rxIn  = cmd.loopBack ? txShift[BYTE_W-1] : misoIn;
  assign mDone = busy && !cmd.abort && (cnt == '0) && sck && (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
      bitCnt  <= '0;
      cnt     <= '0;
      divHold <= '0;
    end else if (cmd.abort) begin
      busy <= 1'b0;
      sck  <= 1'b0;
    end else if (cmd.start) begin
      busy    <= 1'b1;
      sck     <= 1'b0;
      txShift <= cmd.txByte;
      bitCnt  <= '0;
      cnt     <= cmd.div;
      divHold <= cmd.div;
    end else if (busy) begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= divHold;
        if (!sck) begin
          sck     <= 1'b1;
          rxShift <= {rxShift[BYTE_W-2:0], rxIn};
        end else begin
          sck     <= 1'b0;
          txShift <= {txShift[BYTE_W-2:0], 1'b0};
          bitCnt  <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) busy <= 1'b0;
        end
      end
    end
  end

  assign slvActive = !cmd.master && cmd.slaveSel;
  assign sRise     = sckSync[1] && !sckSync[2];
  assign sFall     = !sckSync[1] && sckSync[2];
  assign sDone     = slvActive && sRise && (slvBits == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      mosiSync <= '0;
      slvShift <= '0;
      slvTx    <= '0;
      slvBits  <= '0;
    end else begin
      sckSync  <= {sckSync[1:0], sckIn};
      mosiSync <= {mosiSync[0], mosiIn};
      if (!slvActive) begin
        slvBits <= '0;
        slvTx   <= cmd.txByte;
      end else begin
        if (sRise) begin
          slvShift <= {slvShift[BYTE_W-2:0], mosiSync[1]};
          slvBits  <= slvBits + 1'b1;
        end
        if (sFall) slvTx <= {slvTx[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign deliver = mDone || sDone;
  assign newByte = mDone ? rxShift : {slvShift[BYTE_W-2:0], mosiSync[1]};

  // arrival of a byte outranks both the read and the overrun clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxFull  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (deliver) begin
        rxData <= newByte;
        rxFull <= 1'b1;
      end else if (cmd.rxRead) begin
        rxFull <= 1'b0;
      end
      if (deliver && rxFull && !cmd.rxRead) overrun <= 1'b1;
      else if (cmd.ovrClear) overrun <= 1'b0;
    end
  end

  assign stat.busy    = busy;
  assign stat.rxFull  = rxFull;
  assign stat.overrun = overrun;
  assign stat.rxData  = rxData;
  assign sckOut       = sck;
  assign mosiOut      = cmd.master ? txShift[BYTE_W-1] : 1'b0;
  assign misoOut      = slvActive ? slvTx[BYTE_W-1] : 1'b0;
endmodule

// File: rtl/spiCsCtrl.sv
module spiCsCtrl
  import spiPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              sckOut,
  input  logic              sckIn,
  output logic              mosiOut,
  input  logic              mosiIn,
  input  logic              misoIn,
  output logic              misoOut,
  output logic [CS_W-1:0]   pcsN,
  input  logic              faultN
);
  dpCmd_t   dpCmd;
  dpStat_t  dpStat;
  modeReg_t modeWord;
  logic     lockBit;
  logic     modeFault;

  spiCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .addr      (addr),
    .wrData    (wrData),
    .rdData    (rdData),
    .faultN    (faultN),
    .pcsN      (pcsN),
    .cmd       (dpCmd),
    .stat      (dpStat),
    .modeWord  (modeWord),
    .lockBit   (lockBit),
    .modeFault (modeFault)
  );

  spiDatapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (dpCmd),
    .stat    (dpStat),
    .sckOut  (sckOut),
    .mosiOut (mosiOut),
    .misoIn  (misoIn),
    .misoOut (misoOut),
    .sckIn   (sckIn),
    .mosiIn  (mosiIn)
  );
endmodule

// File: rtl/spiCtrlChecker.sv
module spiCtrlChecker
  import spiPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [CS_W-1:0]   pcsN,
  input logic              sckOut,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input dpCmd_t            dpCmd,
  input dpStat_t           dpStat,
  input modeReg_t          modeWord,
  input logic              lockBit,
  input logic              modeFault
);
  assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pcsN) != CS_NONE && pcsN != $past(pcsN)) |-> pcsN == CS_NONE);

  assert_cs_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    sckOut |-> $stable(pcsN));

  assert_rx_consume_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dpStat.rxFull) |-> $past(dpCmd.rxRead));

  assert_wait_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dpCmd.start && modeWord.waitRead) |-> !dpStat.rxFull);

  assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (modeFault && $past(modeFault)) |-> (!sckOut && pcsN == CS_NONE));

  assert_lock_R11: assert property (@(posedge clk) disable iff (!rstN)
    (lockBit && wrEn && addr == A_MODE) |=> $stable(modeWord));

  assert_slave_lines_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!modeWord.master && !$past(modeWord.master)) |-> pcsN == CS_NONE);
endmodule

bind spiCsCtrl spiCtrlChecker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pcsN      (pcsN),
  .sckOut    (sckOut),
  .wrEn      (wrEn),
  .addr      (addr),
  .dpCmd     (dpCmd),
  .dpStat    (dpStat),
  .modeWord  (modeWord),
  .lockBit   (lockBit),
  .modeFault (modeFault)
);

// File: tb/test_spiCsCtrl.sv
module test_spiCsCtrl;
  import spiPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [REG_W-1:0] wrData = '0;
  logic [REG_W-1:0] rdData;
  logic sckOut, mosiOut, misoOut;
  logic sckIn = 1'b0, mosiIn = 1'b0, misoIn = 1'b0, faultN = 1'b1;
  logic [CS_W-1:0] pcsN;

  always #2 clk = ~clk;

  spiCsCtrl i_spiCsCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .sckOut(sckOut), .sckIn(sckIn),
    .mosiOut(mosiOut), .mosiIn(mosiIn), .misoIn(misoIn), .misoOut(misoOut),
    .pcsN(pcsN), .faultN(faultN)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // scoreboard of serial output bytes
  logic [7:0] expMosi[$];
  logic [7:0] misoByte = 8'h00;
  logic [7:0] monByte = 8'h00;
  int monBits = 0, highRun = 0, lastHigh = 0, fRun = 0, lastGap = 0;
  int fTotal = 0, riseTotal = 0;
  logic prevSck = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (pcsN == CS_NONE) begin
        monBits = 0; fRun++; fTotal++;
      end else begin
        if (fRun > 0) lastGap = fRun;
        fRun = 0;
      end
      if (sckOut && !prevSck) begin
        monByte = {monByte[6:0], mosiOut};
        monBits++; riseTotal++; highRun = 1;
      end else if (sckOut) begin
        highRun++;
      end
      if (!sckOut && prevSck) lastHigh = highRun;
      prevSck = sckOut;
      if (monBits == 8) begin
        monBits = 0;
        if (expMosi.size() == 0) chk("R2", "unexpected serial byte", monByte, 0);
        else chk("R2", "serial output byte", monByte, expMosi.pop_front());
      end
      misoIn = misoByte[7 - monBits];
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk("WATCHDOG", "run timed out", 1, 0);
    finishRun();
  end

  task automatic wr(logic [ADDR_W-1:0] a, logic [REG_W-1:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [REG_W-1:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic waitIdle();
    logic [REG_W-1:0] s;
    for (int n = 0; n < 3000; n++) begin
      rd(A_STAT, s);
      if (!s[S_BUSY]) return;
    end
    chk("R2", "transfer never finished", 1, 0);
  endtask

  function automatic logic [REG_W-1:0] mk(bit ms, bit vs, bit dec, bit fo, bit wt, bit lb,
                                          logic [3:0] pcs, logic [7:0] dly);
    return {dly, 4'h0, pcs, 8'h00, lb, 1'b0, wt, fo, 1'b0, dec, vs, ms};
  endfunction

  task automatic xfer(string req, logic [7:0] tx, logic [3:0] code, logic [7:0] expRx);
    logic [REG_W-1:0] d;
    expMosi.push_back(tx);
    wr(A_TX, {12'h0, code, 8'h00, tx});
    waitIdle();
    rd(A_RX, d);
    chk(req, "received byte", d[7:0], expRx);
  endtask

  initial begin
    logic [REG_W-1:0] d, keep;
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "select lines", pcsN, 4'hF);
    chk("R1", "serial clock", sckOut, 0);
    rd(A_STAT, d); chk("R1", "status", d, 32'h2);
    rd(A_MODE, d); chk("R1", "mode word", d, 0);

    wr(A_TIM0 + 4'd0, 0); wr(A_TIM0 + 4'd1, 2);
    wr(A_TIM0 + 4'd2, 1); wr(A_TIM0 + 4'd3, 4);

    // R2 plain master transfer, direct lines, fixed code 4'hE -> slot 0
    wr(A_MODE, mk(1, 0, 0, 0, 0, 0, 4'hE, 8'd3));
    misoByte = 8'h3C;
    xfer("R2", 8'hA5, 4'h0, 8'h3C);
    chk("R2", "half period of slot 0", lastHigh, 1);
    chk("R4", "fixed code held on lines", pcsN, 4'hE);

    // R3 loopback, same code: no gap (R6)
    base = fTotal;
    wr(A_MODE, mk(1, 0, 0, 0, 0, 1, 4'hE, 8'd3));
    misoByte = 8'hFF;
    xfer("R3", 8'h5A, 4'h0, 8'h5A);
    chk("R6", "no release between same-code bytes", fTotal - base, 0);

    // R5 direct lines: code 4'hB -> slot 2 (div 1); R6 gap
    wr(A_MODE, mk(1, 0, 0, 0, 0, 1, 4'hB, 8'd3));
    xfer("R5", 8'hC3, 4'h0, 8'hC3);
    chk("R5", "half period of slot 2", lastHigh, 2);
    chk("R6", "gap at least delay count", lastGap >= 3, 1);
    chk("R4", "lines after code change", pcsN, 4'hB);

    // R4 variable code, R5 decoded slots
    wr(A_MODE, mk(1, 1, 1, 0, 0, 1, 4'h0, 8'd3));
    xfer("R4", 8'h96, 4'h5, 8'h96);
    chk("R4", "per-word code on lines", pcsN, 4'h5);
    chk("R5", "decoded code 5 uses slot 1", lastHigh, 3);
    xfer("R5", 8'h69, 4'hD, 8'h69);
    chk("R5", "decoded code 13 uses slot 3", lastHigh, 5);
    wr(A_MODE, mk(1, 0, 1, 0, 0, 1, 4'h9, 8'd3));
    xfer("R5", 8'h0F, 4'h0, 8'h0F);
    chk("R5", "decoded fixed code 9 uses slot 2", lastHigh, 2);
    chk("R4", "fixed decoded code on lines", pcsN, 4'h9);

    // R8 overrun and its clear
    expMosi.push_back(8'h11); wr(A_TX, 32'h11); waitIdle();
    expMosi.push_back(8'h22); wr(A_TX, 32'h22); waitIdle();
    rd(A_STAT, d); chk("R8", "status after overrun", d, 32'h7);
    rd(A_RX, d);   chk("R8", "newest byte kept", d[7:0], 8'h22);
    wr(A_STAT, 32'h4);
    rd(A_STAT, d); chk("R8", "status after clear", d, 32'h2);

    // R9 read lands on the completion edge (slot 0, div 0)
    wr(A_MODE, mk(1, 1, 1, 0, 0, 1, 4'h0, 8'd3));
    expMosi.push_back(8'h33); wr(A_TX, 32'h33); waitIdle();
    expMosi.push_back(8'h44); wr(A_TX, 32'h44);
    begin
      int rises = 0;
      logic pv = sckOut;
      for (int n = 0; n < 2000 && rises < 8; n++) begin
        @(negedge clk);
        if (sckOut && !pv) rises++;
        pv = sckOut;
      end
      rdEn = 1'b1; addr = A_RX; #1 d = rdData;
      @(negedge clk); rdEn = 1'b0;
    end
    chk("R9", "coincident read returns older byte", d[7:0], 8'h33);
    rd(A_STAT, d); chk("R9", "full kept, no overrun", d, 32'h3);
    rd(A_RX, d);   chk("R9", "later read gets new byte", d[7:0], 8'h44);

    // R7 wait for read
    wr(A_MODE, mk(1, 1, 1, 0, 1, 1, 4'h0, 8'd3));
    expMosi.push_back(8'h55); wr(A_TX, 32'h55); waitIdle();
    base = riseTotal;
    expMosi.push_back(8'h66); wr(A_TX, 32'h66);
    repeat (40) @(negedge clk);
    chk("R7", "no clock while unread", riseTotal - base, 0);
    rd(A_STAT, d); chk("R7", "busy and full while held", {d[S_BUSY], d[S_RXFULL]}, 2'b11);
    rd(A_RX, d);   chk("R7", "held byte", d[7:0], 8'h55);
    waitIdle();
    rd(A_RX, d);   chk("R7", "released transfer", d[7:0], 8'h66);
    rd(A_STAT, d); chk("R7", "no overrun", d[S_OVR], 0);

    // R10 mode fault
    wr(A_TIM0 + 4'd3, 20);
    wr(A_MODE, mk(1, 1, 1, 0, 0, 1, 4'h0, 8'd3));
    base = riseTotal;
    wr(A_TX, {12'h0, 4'hC, 16'h0077});
    for (int n = 0; n < 2000 && riseTotal < base + 2; n++) @(negedge clk);
    faultN = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10", "lines released on fault", pcsN, 4'hF);
    chk("R10", "clock low on fault", sckOut, 0);
    rd(A_STAT, d); chk("R10", "fault flag", d[S_FAULT], 1);
    faultN = 1'b1;
    base = riseTotal;
    wr(A_TX, {12'h0, 4'hC, 16'h0078});
    repeat (40) @(negedge clk);
    chk("R10", "no transfer while faulted", riseTotal - base, 0);
    expMosi.push_back(8'h78);
    wr(A_STAT, 32'h8);
    waitIdle();
    rd(A_RX, d);   chk("R10", "transfer after clear", d[7:0], 8'h78);
    rd(A_STAT, d); chk("R10", "fault cleared", d[S_FAULT], 0);
    wr(A_MODE, mk(1, 1, 1, 1, 0, 1, 4'h0, 8'd3));
    faultN = 1'b0;
    xfer("R10", 8'h79, 4'hC, 8'h79);
    rd(A_STAT, d); chk("R10", "detection disabled", d[S_FAULT], 0);
    faultN = 1'b1;
    repeat (4) @(negedge clk);

    // R11 lock
    rd(A_MODE, keep);
    wr(A_LOCK, 1); wr(A_MODE, 0);
    rd(A_MODE, d); chk("R11", "locked mode unchanged", d, keep);
    wr(A_LOCK, 0); wr(A_MODE, 0);
    rd(A_MODE, d); chk("R11", "unlocked mode written", d, 0);

    // R12 slave reception
    repeat (2) @(negedge clk);
    chk("R12", "slave lines released", pcsN, 4'hF);
    faultN = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 7; b >= 0; b--) begin
      mosiIn = b[0] ? 1'b0 : 1'b1;
      mosiIn = 8'hC6 >> b;
      repeat (4) @(negedge clk); sckIn = 1'b1;
      repeat (4) @(negedge clk); sckIn = 1'b0;
    end
    repeat (4) @(negedge clk);
    faultN = 1'b1;
    rd(A_STAT, d); chk("R12", "slave receive full", d[S_RXFULL], 1);
    rd(A_RX, d);   chk("R12", "slave byte", d[7:0], 8'hC6);
    chk("R2", "scoreboard drained", expMosi.size(), 0);
    finishRun();
  end
endmodule